// File: doc/BRIEF.md
# Four-Function Bit-Slice ALU

This block is a purely combinational arithmetic logic unit assembled from identical one-bit slices. Each slice holds a single full adder and two logic gates. A two-bit operation select chooses bitwise OR, bitwise AND, subtraction or addition. A per-slice four-to-one multiplexer drives the chosen result bit onto the result bus. The slices are chained through a ripple carry path whose length follows the width parameter.

Addition and subtraction share the same full adder in every slice. To subtract, each slice inverts its B bit and the least significant carry input is forced to 1. The carry output reports the carry out of the most significant slice for the two arithmetic operations. It is held at 0 for the two logic operations. A generate parameter chooses how the result multiplexer is built: a select-indexed case, or an AND-OR tree fed by a one-hot decode. Both builds give identical behaviour.

Top module: `slice_alu`

## Requirements
- R1: With `op_sel` = 2'b00, `result` equals the bitwise OR of `opnd_a` and `opnd_b`.
- R2: With `op_sel` = 2'b01, `result` equals the bitwise AND of `opnd_a` and `opnd_b`.
- R3: With `op_sel` = 2'b11, {`carry_out`, `result`} equals `opnd_a` + `opnd_b` + `carry_in` as a WIDTH+1 bit unsigned sum.
- R4: With `op_sel` = 2'b10, `result` equals (`opnd_a` - `opnd_b`) modulo 2^WIDTH.
- R5: With `op_sel` = 2'b10, `carry_out` is 1 exactly when `opnd_a` >= `opnd_b` as unsigned values, so 0 signals a borrow.
- R6: With `op_sel` = 2'b10, the value of `carry_in` has no effect on `result` or `carry_out`.
- R7: With `op_sel` = 2'b00 or 2'b01, `carry_out` is 0 for every operand and `carry_in` value.
- R8: The block holds no state, so its outputs depend only on the present inputs.
- R9: The width is a parameter with a default of 4, and the behaviour above holds at any width of 1 or more, including 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| carry_in | input | 1 | Carry into bit 0 for addition; ignored otherwise |
| op_sel | input | 2 | Operation: 00 OR, 01 AND, 10 subtract, 11 add |
| result | output | WIDTH | Selected operation result |
| carry_out | output | 1 | Carry out of the top slice for add and subtract; 0 for OR and AND |

## Verification
The bound checker compares the ports against an arithmetic reference whenever the inputs are known. It covers the OR and AND results, the add sum with its carry, the subtract difference, the no-borrow carry, and the zeroed carry for logic operations. Only the bench scenarios can show the remaining properties. These are that `carry_in` is truly ignored in subtract mode, which shows in matched vector pairs that differ only in that input, and that the behaviour holds at two widths built with two different multiplexer variants. The bench also shows that the outputs follow the inputs in the same cycle with no state.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

   typedef enum logic [1:0] {
      SEL_OR  = 2'b00,
      SEL_AND = 2'b01,
      SEL_SUB = 2'b10,
      SEL_ADD = 2'b11
   } alu_sel_e;

   localparam int unsigned NUM_OPS = 4;

   function automatic logic sel_is_arith(input alu_sel_e s);
      return s[1];
   endfunction

endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);
   logic half_x;
   assign half_x = a_i ^ b_i;
   assign s_o    = half_x ^ c_i;
   assign c_o    = (a_i & b_i) | (half_x & c_i);
endmodule

// File: rtl/alu_slice.sv
module alu_slice
   import alu_slice_pkg::*;
#(
   parameter int unsigned MUX_VARIANT = 0
) (
   input  logic     a_i,
   input  logic     b_i,
   input  logic     c_i,
   input  alu_sel_e sel_i,
   output logic     y_o,
   output logic     c_o
);
   logic b_eff;
   logic sum_bit;
   logic or_bit;
   logic and_bit;

   // Subtraction reuses the adder with B inverted.
   assign b_eff   = b_i ^ (sel_i == SEL_SUB);
   assign or_bit  = a_i | b_i;
   assign and_bit = a_i & b_i;

   alu_full_adder u_fa (
      .a_i (a_i),
      .b_i (b_eff),
      .c_i (c_i),
      .s_o (sum_bit),
      .c_o (c_o)
   );

   generate
      if (MUX_VARIANT == 0) begin : g_case_mux
         always_comb begin
            unique case (sel_i)
               SEL_OR:  y_o = or_bit;
               SEL_AND: y_o = and_bit;
               default: y_o = sum_bit;
            endcase
         end
      end else begin : g_andor_mux
         logic [NUM_OPS-1:0] onehot;
         logic [NUM_OPS-1:0] cand;
         always_comb begin
            onehot = '0;
            onehot[sel_i] = 1'b1;
         end
         assign cand = {sum_bit, sum_bit, and_bit, or_bit};
         assign y_o  = |(onehot & cand);
      end
   endgenerate
endmodule

// File: rtl/alu_carry_ctrl.sv
module alu_carry_ctrl
   import alu_slice_pkg::*;
(
   input  alu_sel_e sel_i,
   input  logic     ext_cin_i,
   input  logic     msb_cout_i,
   output logic     lsb_cin_o,
   output logic     carry_o
);
   always_comb begin
      unique case (sel_i)
         SEL_SUB: lsb_cin_o = 1'b1;
         SEL_ADD: lsb_cin_o = ext_cin_i;
         default: lsb_cin_o = 1'b0;
      endcase
   end

   assign carry_o = sel_is_arith(sel_i) & msb_cout_i;
endmodule

// File: rtl/slice_alu.sv
module slice_alu
   import alu_slice_pkg::*;
#(
   parameter int unsigned WIDTH       = 4,
   parameter int unsigned MUX_VARIANT = 0
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic             carry_in,
   input  logic [1:0]       op_sel,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);
   localparam int unsigned CHAIN_LEN = WIDTH + 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("slice_alu: WIDTH must be at least 1");
      end
      if (MUX_VARIANT > 1) begin : g_bad_variant
         $error("slice_alu: MUX_VARIANT must be 0 or 1");
      end
   endgenerate

   alu_sel_e               sel;
   logic [CHAIN_LEN-1:0]   chain;

   assign sel = alu_sel_e'(op_sel);

   alu_carry_ctrl u_cctl (
      .sel_i      (sel),
      .ext_cin_i  (carry_in),
      .msb_cout_i (chain[WIDTH]),
      .lsb_cin_o  (chain[0]),
      .carry_o    (carry_out)
   );

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_slice
         alu_slice #(.MUX_VARIANT(MUX_VARIANT)) u_slice (
            .a_i   (opnd_a[i]),
            .b_i   (opnd_b[i]),
            .c_i   (chain[i]),
            .sel_i (sel),
            .y_o   (result[i]),
            .c_o   (chain[i+1])
         );
      end
   endgenerate
endmodule

// File: rtl/slice_alu_checker.sv
module slice_alu_checker #(
   parameter int unsigned WIDTH = 4
) (
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic             carry_in,
   input logic [1:0]       op_sel,
   input logic [WIDTH-1:0] result,
   input logic             carry_out
);
   logic [WIDTH:0] add_ref;
   logic [WIDTH:0] diff_ref;

   assign add_ref  = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in};
   assign diff_ref = {1'b0, opnd_a} - {1'b0, opnd_b};

   always_comb begin
      if (!$isunknown({opnd_a, opnd_b, carry_in, op_sel})) begin
         if (op_sel == 2'b00) begin
            assert_or_R1: assert (result == (opnd_a | opnd_b))
               else $error("R1 OR result wrong");
         end
         if (op_sel == 2'b01) begin
            assert_and_R2: assert (result == (opnd_a & opnd_b))
               else $error("R2 AND result wrong");
         end
         if (op_sel == 2'b11) begin
            assert_add_R3: assert ({carry_out, result} == add_ref)
               else $error("R3 add sum wrong");
         end
         if (op_sel == 2'b10) begin
            assert_sub_R4: assert (result == diff_ref[WIDTH-1:0])
               else $error("R4 difference wrong");
            assert_noborrow_R5: assert (carry_out == (opnd_a >= opnd_b))
               else $error("R5 subtract carry wrong");
         end
         if (!op_sel[1]) begin
            assert_logic_carry_R7: assert (carry_out == 1'b0)
               else $error("R7 carry not zero in logic op");
         end
      end
   end
endmodule

bind slice_alu slice_alu_checker #(.WIDTH(WIDTH)) u_chk (
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .carry_in  (carry_in),
   .op_sel    (op_sel),
   .result    (result),
   .carry_out (carry_out)
);

// File: tb/tb_slice_alu.sv
module tb_slice_alu;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;   // 50 MHz

   logic [3:0]  a4, b4, res4;
   logic [15:0] a16, b16, res16;
   logic        cin, c4, c16;
   logic [1:0]  op;

   // Default width, case multiplexer (R9)
   slice_alu dut (
      .opnd_a(a4), .opnd_b(b4), .carry_in(cin), .op_sel(op),
      .result(res4), .carry_out(c4)
   );

   // Width 16, AND-OR multiplexer (R9)
   slice_alu #(.WIDTH(16), .MUX_VARIANT(1)) dut_w16 (
      .opnd_a(a16), .opnd_b(b16), .carry_in(cin), .op_sel(op),
      .result(res16), .carry_out(c16)
   );

   typedef struct {
      longint e4;
      bit     ec4;
      longint e16;
      bit     ec16;
      string  tag;
   } item_t;

   item_t q[$];
   int n_cmp  = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done   = 0;

   function automatic void model(input int w, input longint a, input longint b,
                                 input bit ci, input bit [1:0] o,
                                 output longint r, output bit co);
      longint m;
      longint t;
      m = longint'(1) << w;
      case (o)
         2'b00: begin r = a | b; co = 0; end
         2'b01: begin r = a & b; co = 0; end
         2'b10: begin r = (a - b + m) % m; co = (a >= b); end
         default: begin t = a + b + longint'(ci); r = t % m; co = (t >= m); end
      endcase
   endfunction

   task automatic step(input logic [3:0] xa4, input logic [3:0] xb4,
                       input logic [15:0] xa16, input logic [15:0] xb16,
                       input bit ci, input bit [1:0] o, input string tag);
      item_t it;
      @(posedge clk);
      a4 = xa4; b4 = xb4; a16 = xa16; b16 = xb16; cin = ci; op = o;
      model(4, longint'(xa4), longint'(xb4), ci, o, it.e4, it.ec4);
      model(16, longint'(xa16), longint'(xb16), ci, o, it.e16, it.ec16);
      it.tag = tag;
      q.push_back(it);
   endtask

   function automatic string tag_of(input bit [1:0] o, input bit ci);
      case (o)
         2'b00: return "R1/R7";
         2'b01: return "R2/R7";
         2'b10: return ci ? "R4/R5/R6" : "R4/R5";
         default: return "R3";
      endcase
   endfunction

   // Monitor: compares away from the driving edge (R8: no state, same cycle)
   always @(negedge clk) begin
      if (!rst && q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         n_cmp++;
         if (longint'(res4) != it.e4 || c4 != it.ec4) begin
            n_fail++;
            $display("FAIL %s w4: got res=%h c=%b expected res=%h c=%b",
                     it.tag, res4, c4, it.e4[3:0], it.ec4);
         end
         n_cmp++;
         if (longint'(res16) != it.e16 || c16 != it.ec16) begin
            n_fail++;
            $display("FAIL %s w16 (R9): got res=%h c=%b expected res=%h c=%b",
                     it.tag, res16, c16, it.e16[15:0], it.ec16);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

   initial begin
      a4 = '0; b4 = '0; a16 = '0; b16 = '0; cin = 0; op = 2'b00;
      repeat (3) @(posedge clk);
      rst = 0;

      // Initial state: all-zero inputs give zero result and carry (R1, R7)
      step(4'h0, 4'h0, 16'h0000, 16'h0000, 0, 2'b00, "R1/R7 reset");

      // Exhaustive width-4 sweep of every select code and carry_in value
      for (int o = 0; o < 4; o++)
         for (int c = 0; c < 2; c++)
            for (int a = 0; a < 16; a++)
               for (int b = 0; b < 16; b++)
                  step(4'(a), 4'(b), 16'($urandom), 16'($urandom),
                       1'(c), 2'(o), tag_of(2'(o), 1'(c)));

      // Width-16 corner cases
      step(4'hF, 4'h1, 16'hFFFF, 16'h0001, 0, 2'b11, "R3 wrap");
      step(4'hF, 4'hF, 16'hFFFF, 16'hFFFF, 1, 2'b11, "R3 max");
      step(4'h0, 4'h1, 16'h0000, 16'h0001, 0, 2'b10, "R4/R5 borrow");
      step(4'h0, 4'h1, 16'h0000, 16'h0001, 1, 2'b10, "R6 borrow cin");
      step(4'h5, 4'h5, 16'h8000, 16'h8000, 0, 2'b10, "R5 equal");
      step(4'h5, 4'h5, 16'h8000, 16'h8000, 1, 2'b10, "R6 equal cin");
      step(4'hF, 4'hF, 16'hFFFF, 16'hFFFF, 1, 2'b00, "R7 or cin");
      step(4'hF, 4'hF, 16'hFFFF, 16'hFFFF, 1, 2'b01, "R7 and cin");

      // Random width-16 vectors; subtract pairs differ only in carry_in (R6)
      for (int k = 0; k < 600; k++) begin
         logic [15:0] ra, rb;
         bit [1:0] ro;
         bit rc;
         ra = 16'($urandom); rb = 16'($urandom);
         ro = 2'($urandom); rc = 1'($urandom);
         step(ra[3:0], rb[3:0], ra, rb, rc, ro, tag_of(ro, rc));
         if (ro == 2'b10)
            step(ra[3:0], rb[3:0], ra, rb, ~rc, ro, "R6 pair");
      end

      // R8: input change alone, no clocked state
      step(4'h9, 4'h3, 16'h1234, 16'h0F0F, 0, 2'b11, "R3/R8");
      step(4'h9, 4'h3, 16'h1234, 16'h0F0F, 0, 2'b01, "R2/R8");

      while (q.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end
endmodule